// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache controller with two ways per set. It sits between a processor that makes word loads and stores and a memory that moves whole lines. A store that hits changes only the cached line and marks that line dirty. A store that misses first brings its line in (write-allocate) and then merges the word into it. A dirty line goes back to memory only when it is chosen as a victim.

The processor port is a simple request that is held until accepted. `cpu_ready` rises in the same cycle as a hitting request, and a load's data is valid while it is high. On a miss the controller picks a victim way. It writes that line back if it is dirty, requests the new line, and installs it. It then replays the held request, which now hits. A parameter selects the replacement policy. The first option is one least-recently-used bit per set. The second is a single one-bit counter shared by every set. That counter advances on every clock, on every completed access or on every line fill, as chosen by a second parameter.

The memory side uses a request/acknowledge handshake on line addresses. `mem_req` and its address stay stable until a one-cycle `mem_ack`. For a write-back, `mem_we` is high and `mem_wdata` carries the line. For a fill, `mem_rdata` is taken on the acknowledge cycle.

Top module: `cache_2way`

## Requirements
- R1: With the default parameters, address bits [1:0] select a byte and are ignored, bits [3:2] select the word within a four-word line, bits [5:4] select one of four sets, and bits [11:6] form the tag.
- R2: A request hits when either way of the indexed set is valid and holds the request's tag. On a hit, `cpu_ready` is high in the same cycle, and for a load `cpu_rdata` is the matching way's word.
- R3: A store that hits updates the addressed word at the accepting clock edge and marks the line dirty, with no memory traffic.
- R4: On a miss, `cpu_ready` stays low until the line fill is acknowledged. The held request then completes as a hit in the next cycle.
- R5: If the victim way is valid and dirty, it is first written to memory (`mem_we`=1, line address = victim tag and set) before the new line is requested.
- R6: A store miss allocates: the line is fetched, then the store word is merged and the line becomes dirty.
- R7: If the indexed set has an invalid way, the fill goes there without consulting the policy, way 0 before way 1.
- R8: LRU policy (POLICY=0): when both ways are valid, the victim is the way not used most recently by a hit or a fill in that set.
- R9: Random policy (POLICY=1): when both ways are valid, the victim is the shared one-bit counter. With ADVANCE=2 (the default) the counter toggles on every line fill; 0 toggles every clock and 1 toggles on every completed access.
- R10: Reset clears every valid bit, dirty bit, LRU bit and the counter. After reset every access misses, and no former dirty data is written back.
- R11: `mem_req` and `mem_addr` stay stable from request until `mem_ack`.
- R12: Sets are independent: a fill in one set leaves the lines of other sets resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | ADDR_W-OFF_W | Line address {tag, set} |
| mem_wdata | output | WORD_W*LINE_WORDS | Line being written back |
| mem_rdata | input | WORD_W*LINE_WORDS | Line being filled |
| mem_ack | input | 1 | One-cycle completion of the transfer |

## Verification
A hit is due in the cycle its request is presented. The bench drives after a falling edge and samples `cpu_ready` and `cpu_rdata` shortly after, so a hit counts zero wait cycles. With the bench memory answering two cycles after a request is seen, a clean miss completes five cycles after presentation and a dirty miss nine cycles after. The bench counts wait cycles at each falling edge and compares them with these figures. Write-back counts and line addresses are compared once each access has finished. Load data is compared against a word-level reference image that is kept from the stores alone.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
// Shared types and codes for the two-way cache.
package cache_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WRBACK, ST_FILL} ctl_state_t;
    localparam int POL_LRU   = 0;
    localparam int POL_RAND  = 1;
    localparam int ADV_CLOCK = 0;
    localparam int ADV_REF   = 1;
    localparam int ADV_FILL  = 2;
endpackage

// File: rtl/cache_way_store.sv
`timescale 1ns/1ps
// One way of the cache: per-set valid, dirty, tag and line storage plus
// the tag comparator for the indexed set.
// Assumes fill and word write are never requested in the same cycle.
module cache_way_store #(
    parameter int SETS       = 4,
    parameter int TAG_W      = 6,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int SET_W     = $clog2(SETS),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [WSEL_W-1:0] wsel_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              fill_en_i,
    input  logic [LINE_W-1:0] fill_line_i,
    output logic              match_o,
    output logic              valid_o,
    output logic              dirty_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] line_o,
    output logic [WORD_W-1:0] word_o
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    // Status bits: fill makes the line valid and clean, a store dirties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en_i) begin
            valid_q[set_i] <= 1'b1;
            dirty_q[set_i] <= 1'b0;
        end else if (wr_en_i) begin
            dirty_q[set_i] <= 1'b1;
        end
    end

    // Tag and data arrays: whole-line install on fill, word merge on store.
    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[set_i]  <= tag_i;
            data_q[set_i] <= fill_line_i;
        end else if (wr_en_i) begin
            data_q[set_i][wsel_i*WORD_W +: WORD_W] <= wr_data_i;
        end
    end

    // Lookup of the indexed set.
    always_comb begin
        valid_o = valid_q[set_i];
        dirty_o = dirty_q[set_i];
        tag_o   = tag_q[set_i];
        line_o  = data_q[set_i];
        word_o  = line_o[wsel_i*WORD_W +: WORD_W];
        match_o = valid_o && (tag_o == tag_i);
    end
endmodule

// File: rtl/cache_repl.sv
`timescale 1ns/1ps
// Victim selection for a two-way set. Invalid ways are taken first; else
// per-set LRU bits or one shared toggle counter, chosen by POLICY.
// Assumes ref_i marks a completed access and fill_i a line install.
module cache_repl
    import cache_pkg::*;
#(
    parameter int SETS    = 4,
    parameter int POLICY  = POL_LRU,
    parameter int ADVANCE = ADV_FILL,
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [1:0]       valid_i,
    input  logic             ref_i,
    input  logic             ref_way_i,
    input  logic             fill_i,
    input  logic             fill_way_i,
    output logic             victim_o
);
    logic pick;

    if (POLICY == POL_LRU) begin : g_lru
        logic [SETS-1:0] lru_q;
        // Each bit names the way of its set not used most recently.
        always_ff @(posedge clk) begin
            if (!rst_n)      lru_q <= '0;
            else if (fill_i) lru_q[set_i] <= ~fill_way_i;
            else if (ref_i)  lru_q[set_i] <= ~ref_way_i;
        end
        assign pick = lru_q[set_i];
        // After a hit, the other way of that set is the next victim.
        AST_LRU_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_i && !fill_i) |=> (lru_q[$past(set_i)] == ~$past(ref_way_i))); // R8
    end else begin : g_rand
        logic cnt_q;
        logic adv;
        logic unused_inputs;
        assign adv = (ADVANCE == ADV_CLOCK) ? 1'b1 :
                     (ADVANCE == ADV_REF)   ? ref_i : fill_i;
        assign unused_inputs = ^{set_i, ref_way_i, fill_way_i, ref_i, fill_i};
        // Shared modulo-2 counter on the selected schedule.
        always_ff @(posedge clk) begin
            if (!rst_n)   cnt_q <= 1'b0;
            else if (adv) cnt_q <= ~cnt_q;
        end
        assign pick = cnt_q;
    end

    // Prefer an empty way, way 0 first.
    always_comb begin
        if (!valid_i[0])      victim_o = 1'b0;
        else if (!valid_i[1]) victim_o = 1'b1;
        else                  victim_o = pick;
    end
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
// Miss sequencer: idle/lookup, optional write-back, line fill.
// Assumes the processor holds its request stable until cpu_ready.
module cache_ctrl
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic hit_i,
    input  logic victim_i,
    input  logic victim_dirty_i,
    input  logic mem_ack_i,
    output logic ready_o,
    output logic mem_req_o,
    output logic mem_we_o,
    output logic fill_o,
    output logic victim_q_o
);
    ctl_state_t state_q;

    // State and latched victim way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            victim_q_o <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_i && !hit_i) begin
                    victim_q_o <= victim_i;
                    state_q    <= victim_dirty_i ? ST_WRBACK : ST_FILL;
                end
                ST_WRBACK: if (mem_ack_i) state_q <= ST_FILL;
                ST_FILL:   if (mem_ack_i) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs.
    always_comb begin
        ready_o   = (state_q == ST_IDLE) && req_i && hit_i;
        mem_req_o = (state_q != ST_IDLE);
        mem_we_o  = (state_q == ST_WRBACK);
        fill_o    = (state_q == ST_FILL) && mem_ack_i;
    end

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o)); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o))); // R11
endmodule

// File: rtl/cache_2way.sv
`timescale 1ns/1ps
// Two-way set-associative write-back, write-allocate data cache.
// Word requests on the processor side, whole-line handshake on memory side.
// Assumes cpu_valid and its fields are held until cpu_ready.
module cache_2way
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4,
    parameter int POLICY     = POL_LRU,
    parameter int ADVANCE    = ADV_FILL,
    localparam int BYTE_W    = $clog2(WORD_W / 8),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = BYTE_W + WSEL_W,
    localparam int SET_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W    = WORD_W * LINE_WORDS,
    localparam int LADDR_W   = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic [LINE_W-1:0]  mem_rdata,
    input  logic               mem_ack
);
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_in;
    logic [WSEL_W-1:0] wsel;
    logic              unused_byte;

    logic [1:0]        way_match, way_valid, way_dirty;
    logic [TAG_W-1:0]  way_tag  [2];
    logic [LINE_W-1:0] way_line [2];
    logic [WORD_W-1:0] way_word [2];

    logic hit, victim, victim_q, fill_go;

    // Address field split.
    assign set_idx     = cpu_addr[OFF_W +: SET_W];
    assign tag_in      = cpu_addr[ADDR_W-1 -: TAG_W];
    assign wsel        = cpu_addr[BYTE_W +: WSEL_W];
    assign unused_byte = ^cpu_addr[BYTE_W-1:0];

    for (genvar w = 0; w < 2; w++) begin : g_way
        cache_way_store #(
            .SETS(SETS), .TAG_W(TAG_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
        ) u_way (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_idx), .tag_i(tag_in), .wsel_i(wsel),
            .wr_en_i(cpu_ready && cpu_we && way_match[w]),
            .wr_data_i(cpu_wdata),
            .fill_en_i(fill_go && (victim_q == 1'(w))),
            .fill_line_i(mem_rdata),
            .match_o(way_match[w]), .valid_o(way_valid[w]), .dirty_o(way_dirty[w]),
            .tag_o(way_tag[w]), .line_o(way_line[w]), .word_o(way_word[w])
        );
    end

    assign hit = |way_match;

    cache_repl #(.SETS(SETS), .POLICY(POLICY), .ADVANCE(ADVANCE)) u_repl (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx), .valid_i(way_valid),
        .ref_i(cpu_ready), .ref_way_i(way_match[1]),
        .fill_i(fill_go), .fill_way_i(victim_q), .victim_o(victim)
    );

    cache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(cpu_valid), .hit_i(hit),
        .victim_i(victim),
        .victim_dirty_i(way_valid[victim] && way_dirty[victim]),
        .mem_ack_i(mem_ack), .ready_o(cpu_ready), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .fill_o(fill_go), .victim_q_o(victim_q)
    );

    // Data return and memory-side line address and data.
    always_comb begin
        cpu_rdata = way_match[1] ? way_word[1] : way_word[0];
        mem_addr  = mem_we ? {way_tag[victim_q], set_idx} : {tag_in, set_idx};
        mem_wdata = way_line[victim_q];
    end

    AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_match)); // R2
    AST_READY_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R4
    AST_FILL_REPLAYS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && cpu_valid) |=> hit); // R4
    AST_MEM_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr)); // R11
endmodule

// File: tb/tb_cache_2way.sv
`timescale 1ns/1ps
// Line memory model: acknowledges LAT+1 cycles after a request is seen.
module mem_line_model #(
    parameter int LADDR_W = 8,
    parameter int LINE_W  = 128,
    parameter int LAT     = 2
) (
    input  logic               clk,
    input  logic               req,
    input  logic               we,
    input  logic [LADDR_W-1:0] addr,
    input  logic [LINE_W-1:0]  wdata,
    output logic [LINE_W-1:0]  rdata,
    output logic               ack,
    output int                 wb_cnt,
    output logic [LADDR_W-1:0] last_wb,
    output logic               proto_err
);
    logic [LINE_W-1:0]  lines [2**LADDR_W];
    int                 cnt;
    logic [LADDR_W-1:0] held;

    initial begin
        ack = 0; cnt = 0; wb_cnt = 0; last_wb = '0; proto_err = 0; held = '0;
        for (int i = 0; i < 2**LADDR_W; i++)
            for (int j = 0; j < 4; j++)
                lines[i][j*32 +: 32] = 32'hC0DE_0000 + i*4 + j;
    end

    assign rdata = lines[addr];

    always @(posedge clk) begin
        if (ack) begin
            ack <= 0;
            cnt <= 0;
        end else if (req) begin
            if (cnt != 0 && addr != held) proto_err <= 1;
            held <= addr;
            if (cnt == LAT) begin
                ack <= 1;
                if (we) begin
                    lines[addr] <= wdata;
                    wb_cnt      <= wb_cnt + 1;
                    last_wb     <= addr;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end
endmodule

module tb_cache_2way;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic        cpu_valid = 0, cpu_we = 0, sel = 0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;

    logic [31:0]  rd_a, rd_b;
    logic         rdy_a, rdy_b, req_a, req_b, we_a, we_b, ack_a, ack_b;
    logic [7:0]   ma_a, ma_b, lwb_a, lwb_b;
    logic [127:0] wd_a, wd_b, mr_a, mr_b;
    int           wbc_a, wbc_b;
    logic         perr_a, perr_b;

    cache_2way dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid && !sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rd_a), .cpu_ready(rdy_a),
        .mem_req(req_a), .mem_we(we_a), .mem_addr(ma_a), .mem_wdata(wd_a),
        .mem_rdata(mr_a), .mem_ack(ack_a));
    mem_line_model mem_a (.clk(clk), .req(req_a), .we(we_a), .addr(ma_a), .wdata(wd_a),
        .rdata(mr_a), .ack(ack_a), .wb_cnt(wbc_a), .last_wb(lwb_a), .proto_err(perr_a));

    cache_2way #(.POLICY(1), .ADVANCE(2)) dut_rnd (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid && sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rd_b), .cpu_ready(rdy_b),
        .mem_req(req_b), .mem_we(we_b), .mem_addr(ma_b), .mem_wdata(wd_b),
        .mem_rdata(mr_b), .mem_ack(ack_b));
    mem_line_model mem_b (.clk(clk), .req(req_b), .we(we_b), .addr(ma_b), .wdata(wd_b),
        .rdata(mr_b), .ack(ack_b), .wb_cnt(wbc_b), .last_wb(lwb_b), .proto_err(perr_b));

    int n_chk = 0, n_fail = 0;
    logic [31:0] ref_mem [1024];

    // {we, addr, wdata, wait cycles, write-back expected, write-back line}
    localparam int NV = 16;
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 12'h010, 32'h0,        4'd5, 1'b0, 8'h00},
        {1'b0, 12'h014, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b1, 12'h018, 32'h11111111, 4'd0, 1'b0, 8'h00},
        {1'b0, 12'h018, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b1, 12'h054, 32'h55555555, 4'd5, 1'b0, 8'h00},
        {1'b0, 12'h054, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b0, 12'h010, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b0, 12'h090, 32'h0,        4'd9, 1'b1, 8'h05},
        {1'b0, 12'h058, 32'h0,        4'd9, 1'b1, 8'h01},
        {1'b0, 12'h094, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b0, 12'h018, 32'h0,        4'd5, 1'b0, 8'h00},
        {1'b0, 12'h054, 32'h0,        4'd5, 1'b0, 8'h00},
        {1'b0, 12'h020, 32'h0,        4'd5, 1'b0, 8'h00},
        {1'b0, 12'h024, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b0, 12'h018, 32'h0,        4'd0, 1'b0, 8'h00},
        {1'b0, 12'h01B, 32'h0,        4'd0, 1'b0, 8'h00}
    };
    string vreq [NV];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [11:0] addr, input logic [31:0] wd,
                          output int cyc, output logic [31:0] rd);
        logic r;
        @(negedge clk);
        cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_valid = 1; cyc = 0;
        #1;
        r = sel ? rdy_b : rdy_a;
        while (!r && cyc < 100) begin
            @(negedge clk); #1; cyc++;
            r = sel ? rdy_b : rdy_a;
        end
        rd = sel ? rd_b : rd_a;
        @(posedge clk); #1;
        cpu_valid = 0;
    endtask

    task automatic read_chk(input logic [11:0] addr, input int exp_cyc,
                            input logic [31:0] exp_d, input string rq);
        int c; logic [31:0] d;
        access(1'b0, addr, 32'h0, c, d);
        check(c == exp_cyc, rq, $sformatf("wait cycles @%h", addr), c, exp_cyc);
        check(d == exp_d, rq, $sformatf("load data @%h", addr), d, exp_d);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c, wb0;
        logic [31:0] d;
        vreq = '{"R2", "R2", "R3", "R3", "R6", "R6", "R8", "R8",
                 "R8", "R2", "R8", "R8", "R12", "R12", "R12", "R1"};
        for (int k = 0; k < 1024; k++) ref_mem[k] = 32'hC0DE_0000 + k;

        repeat (3) @(posedge clk);
        #1;
        // R10: reset state on the ports
        check(rdy_a == 0, "R10", "ready after reset", 32'(rdy_a), 0);
        check(req_a == 0, "R10", "mem_req after reset", 32'(req_a), 0);
        @(negedge clk); rst_n = 1;

        // Main table on the LRU instance (set 1 tags 0x00,0x01,0x02; set 2).
        for (int i = 0; i < NV; i++) begin
            logic        v_we;
            logic [11:0] v_ad;
            logic [31:0] v_wd;
            int          v_cy;
            v_we = VEC[i][57]; v_ad = VEC[i][56:45]; v_wd = VEC[i][44:13];
            v_cy = int'(VEC[i][12:9]);
            wb0 = wbc_a;
            access(v_we, v_ad, v_wd, c, d);
            check(c == v_cy, (v_cy == 5) ? "R4" : (v_cy == 9) ? "R5" : vreq[i],
                  $sformatf("vec %0d wait cycles", i), c, v_cy);
            check((wbc_a - wb0) == int'(VEC[i][8]), "R5",
                  $sformatf("vec %0d write-back count", i), wbc_a - wb0, 32'(VEC[i][8]));
            if (VEC[i][8])
                check(lwb_a == VEC[i][7:0], "R5", $sformatf("vec %0d write-back line", i),
                      32'(lwb_a), 32'(VEC[i][7:0]));
            if (v_we) ref_mem[v_ad[11:2]] = v_wd;
            else check(d == ref_mem[v_ad[11:2]], vreq[i],
                       $sformatf("vec %0d load data", i), d, ref_mem[v_ad[11:2]]);
        end

        // R10: dirty line then reset; contents discarded without write-back.
        access(1'b1, 12'h018, 32'h22222222, c, d);
        check(c == 0, "R3", "store hit before reset", c, 0);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        wb0 = wbc_a;
        read_chk(12'h018, 5, 32'h11111111, "R10");
        check(wbc_a == wb0, "R10", "no write-back after reset", wbc_a - wb0, 0);
        // R7: second tag of the set fills the empty way, first stays.
        read_chk(12'h090, 5, ref_mem[12'h090 >> 2], "R7");
        check(wbc_a == wb0, "R7", "empty way used, no write-back", wbc_a - wb0, 0);
        read_chk(12'h01C, 0, ref_mem[12'h01C >> 2], "R7");
        ref_mem[12'h018 >> 2] = 32'h11111111;

        // R9: random instance, counter toggles on each fill.
        sel = 1;
        read_chk(12'h010, 5, ref_mem[12'h010 >> 2], "R9");
        read_chk(12'h050, 5, ref_mem[12'h050 >> 2], "R9");
        read_chk(12'h010, 0, ref_mem[12'h010 >> 2], "R9");
        read_chk(12'h090, 5, ref_mem[12'h090 >> 2], "R9");
        read_chk(12'h050, 0, ref_mem[12'h050 >> 2], "R9");
        read_chk(12'h010, 5, ref_mem[12'h010 >> 2], "R9");
        read_chk(12'h090, 0, ref_mem[12'h090 >> 2], "R9");
        read_chk(12'h050, 5, ref_mem[12'h050 >> 2], "R9");
        sel = 0;

        // R11: memory address held stable through each handshake.
        check(perr_a == 0 && perr_b == 0, "R11", "memory address stability",
              32'({perr_a, perr_b}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule